// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds a bank of event counters for cache-level performance monitoring. Each counter is steered by its own 8-bit selector to one line of a wide vector of single-cycle event pulses. A counter advances by one in every cycle where three things hold: the bank-wide run bit is set, that counter's own enable bit is set, and the selected event line is high. Software configures the bank, preloads counters and reads them back through a simple synchronous register bus. The bus carries 64-bit data, so a full counter moves in a single access.

When a counter wraps from its largest value to zero, it latches a pending flag. The interrupt output is raised while any pending flag is not masked. Pending flags are cleared by writing ones. A build-time parameter picks 64-bit or 48-bit counters. In the narrow build, bits 63:48 of a counter always read as zero, writes to those bits are dropped, and the wrap happens at 2^48-1. A read-only identity word tells software which width it is talking to.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset the run control reads 0, the interrupt mask reads all ones (every counter masked), the pending and counter-enable registers read 0, both selector registers read 0xFFFFFFFF, every counter reads 0, and `irq` is low.
- R2: A counter increments by exactly one in each cycle where the run bit, its enable bit and its selected event input are all high. Several counters may count in the same cycle.
- R3: Bit 16 of the control register (0x0408) is the run bit. While it is 0, no counter changes except through a bus write.
- R4: Bit n of the counter-enable register (0x1c00) gates counter n. A counter whose bit is 0 does not count.
- R5: Counter n takes its 8-bit event code from register 0x1d00 (n<4) or 0x1d04 (n>=4), at bits 8*(n mod 4)+7 down to 8*(n mod 4).
- R6: The event code 0xFF selects nothing: a counter holding it never increments, even when input line 255 pulses.
- R7: Counter n sits at 0x1e00+8*n and is read and written as one 64-bit value. A preloaded value is the starting point for later counting. A bus write in the same cycle as an event wins, and the event is dropped.
- R8: In the 48-bit build, bits 63:48 of a counter read as 0 and writes to them are ignored. The counter wraps from 2^48-1 to 0.
- R9: When counter n wraps to zero, bit n of the pending register (0x0808) is set. It stays set until it is cleared.
- R10: `irq` is high exactly when some pending bit is set and its bit in the mask register (0x0800) is 0. A mask bit of 1 suppresses that counter.
- R11: Writing 1 to bit n of 0x080c clears pending bit n, and writing 0 leaves it untouched. If a clear and a wrap of the same counter fall in the same cycle, the bit stays set.
- R12: A read issued in one cycle returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle. The identity word at 0x1cf0 reads 0x40 in the 64-bit build and 0x30 in the 48-bit build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| evt_in | input | NUM_EVT | Single-cycle event pulses, one line per event code |
| irq | output | 1 | Level interrupt from unmasked pending bits |

## Verification
The hardest case to reach is a clear write landing in the very same cycle as a counter wrap. The stimulus first preloads a counter with its all-ones value. It then drives the clear strobe and that counter's event pulse on one falling edge, so both are sampled by the same rising edge. Wraps in general would take 2^48 or 2^64 events to reach, so every overflow case uses a preload written just before the terminal value. A 48-bit instance runs beside the 64-bit one on the same bus, which shows the dropped upper bits and the shorter wrap under identical traffic.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    localparam logic [15:0] A_RUN   = 16'h0408;
    localparam logic [15:0] A_MASK  = 16'h0800;
    localparam logic [15:0] A_PEND  = 16'h0808;
    localparam logic [15:0] A_CLR   = 16'h080c;
    localparam logic [15:0] A_CEN   = 16'h1c00;
    localparam logic [15:0] A_IDENT = 16'h1cf0;
    localparam logic [15:0] A_SEL0  = 16'h1d00;
    localparam logic [15:0] A_CTR0  = 16'h1e00;

    localparam int unsigned RUN_BIT  = 16;
    localparam logic [7:0]  CODE_OFF = 8'hFF;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_RUN,
        RK_MASK,
        RK_PEND,
        RK_CLR,
        RK_CEN,
        RK_IDENT,
        RK_SEL,
        RK_CTR
    } reg_kind_e;

    function automatic reg_kind_e decode_addr(input logic [15:0] a, input int unsigned n_ctr);
        int unsigned nsel;
        nsel = (n_ctr + 3) / 4;
        if (a == A_RUN)        return RK_RUN;
        else if (a == A_MASK)  return RK_MASK;
        else if (a == A_PEND)  return RK_PEND;
        else if (a == A_CLR)   return RK_CLR;
        else if (a == A_CEN)   return RK_CEN;
        else if (a == A_IDENT) return RK_IDENT;
        else if (a[1:0] == 2'b00 && a >= A_SEL0 &&
                 32'(a) < 32'(A_SEL0) + 4 * nsel)  return RK_SEL;
        else if (a[2:0] == 3'b000 && a >= A_CTR0 &&
                 32'(a) < 32'(A_CTR0) + 8 * n_ctr) return RK_CTR;
        return RK_NONE;
    endfunction

endpackage

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
    import evt_ctr_pkg::*;
#(
    parameter int NUM_EVT = 256,
    parameter int CW      = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_ok,
    input  logic [7:0]         code,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               load,
    input  logic [CW-1:0]      load_val,
    output logic [CW-1:0]      value,
    output logic               wrap
);

    localparam int PADW = 256;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } slice_s;

    slice_s            d, q;
    logic [PADW-1:0]   evt_pad;
    logic              hit;

    always_comb begin
        evt_pad = PADW'(evt_in);
        hit     = count_ok && (code != CODE_OFF) && evt_pad[code];
        d       = q;
        wrap    = 1'b0;
        if (load) begin
            d.cnt = load_val;
        end else if (hit) begin
            d.cnt = q.cnt + 1'b1;
            wrap  = &q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign value = q.cnt;

endmodule

// File: rtl/evt_ctr_csr.sv
module evt_ctr_csr
    import evt_ctr_pkg::*;
#(
    parameter int          NUM_CTR = 8,
    parameter int          CW      = 64,
    parameter logic [31:0] IDENT   = 32'h0000_0040
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [15:0]           bus_addr,
    input  logic [63:0]           bus_wdata,
    input  logic [NUM_CTR-1:0]    wrap,
    input  logic [NUM_CTR*CW-1:0] ctr_vals,
    output logic                  run,
    output logic [NUM_CTR-1:0]    ctr_en,
    output logic [NUM_CTR*8-1:0]  ctr_code,
    output logic [NUM_CTR-1:0]    ctr_load,
    output logic [CW-1:0]         ctr_load_val,
    output logic [NUM_CTR-1:0]    irq_mask,
    output logic [NUM_CTR-1:0]    irq_pend,
    output logic [63:0]           bus_rdata,
    output logic                  bus_rvalid
);

    localparam int NSEL = (NUM_CTR + 3) / 4;
    localparam int IW   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam int SW   = (NSEL > 1) ? $clog2(NSEL) : 1;

    typedef struct packed {
        logic                   run;
        logic [NUM_CTR-1:0]     en;
        logic [NUM_CTR-1:0]     mask;
        logic [NUM_CTR-1:0]     pend;
        logic [NSEL*32-1:0]     sel;
        logic [63:0]            rdata;
        logic                   rvalid;
    } csr_s;

    csr_s               d, q;
    reg_kind_e          kind;
    logic [15:0]        sel_off;
    logic [15:0]        ctr_off;
    logic [SW-1:0]      sel_idx;
    logic [IW-1:0]      ctr_idx;
    logic [NUM_CTR-1:0] clr;

    always_comb begin
        kind     = decode_addr(bus_addr, NUM_CTR);
        sel_off  = bus_addr - A_SEL0;
        ctr_off  = bus_addr - A_CTR0;
        sel_idx  = sel_off[SW+1:2];
        ctr_idx  = ctr_off[IW+2:3];
        clr      = '0;
        ctr_load = '0;
        d        = q;
        d.rvalid = bus_rd;

        if (bus_wr) begin
            case (kind)
                RK_RUN:  d.run = bus_wdata[RUN_BIT];
                RK_MASK: d.mask = bus_wdata[NUM_CTR-1:0];
                RK_CLR:  clr = bus_wdata[NUM_CTR-1:0];
                RK_CEN:  d.en = bus_wdata[NUM_CTR-1:0];
                RK_SEL:  d.sel[int'(sel_idx)*32 +: 32] = bus_wdata[31:0];
                RK_CTR:  ctr_load[ctr_idx] = 1'b1;
                default: ;
            endcase
        end

        // a wrap in the same cycle as a clear keeps the bit set
        d.pend = (q.pend & ~clr) | wrap;

        if (bus_rd) begin
            d.rdata = '0;
            case (kind)
                RK_RUN:   d.rdata[RUN_BIT] = q.run;
                RK_MASK:  d.rdata[NUM_CTR-1:0] = q.mask;
                RK_PEND:  d.rdata[NUM_CTR-1:0] = q.pend;
                RK_CEN:   d.rdata[NUM_CTR-1:0] = q.en;
                RK_IDENT: d.rdata[31:0] = IDENT;
                RK_SEL:   d.rdata[31:0] = q.sel[int'(sel_idx)*32 +: 32];
                RK_CTR:   d.rdata[CW-1:0] = ctr_vals[int'(ctr_idx)*CW +: CW];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run    <= 1'b0;
            q.en     <= '0;
            q.mask   <= '1;
            q.pend   <= '0;
            q.sel    <= '1;
            q.rdata  <= '0;
            q.rvalid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run          = q.run;
    assign ctr_en       = q.en;
    assign ctr_code     = q.sel[NUM_CTR*8-1:0];
    assign ctr_load_val = bus_wdata[CW-1:0];
    assign irq_mask     = q.mask;
    assign irq_pend     = q.pend;
    assign bus_rdata    = q.rdata;
    assign bus_rvalid   = q.rvalid;

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTR  = 8,
    parameter int NUM_EVT  = 256,
    parameter bit CTR_WIDE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [15:0]        bus_addr,
    input  logic [63:0]        bus_wdata,
    output logic [63:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);

    localparam int          CW    = CTR_WIDE ? 64 : 48;
    localparam logic [31:0] IDENT = CTR_WIDE ? 32'h0000_0040 : 32'h0000_0030;

    logic                  run;
    logic [NUM_CTR-1:0]    ctr_en;
    logic [NUM_CTR*8-1:0]  ctr_code;
    logic [NUM_CTR-1:0]    ctr_load;
    logic [CW-1:0]         ctr_load_val;
    logic [NUM_CTR-1:0]    irq_mask;
    logic [NUM_CTR-1:0]    irq_pend;
    logic [NUM_CTR-1:0]    wrap;
    logic [NUM_CTR*CW-1:0] ctr_vals;

    evt_ctr_csr #(
        .NUM_CTR (NUM_CTR),
        .CW      (CW),
        .IDENT   (IDENT)
    ) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .wrap         (wrap),
        .ctr_vals     (ctr_vals),
        .run          (run),
        .ctr_en       (ctr_en),
        .ctr_code     (ctr_code),
        .ctr_load     (ctr_load),
        .ctr_load_val (ctr_load_val),
        .irq_mask     (irq_mask),
        .irq_pend     (irq_pend),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slice
        evt_ctr_slice #(
            .NUM_EVT (NUM_EVT),
            .CW      (CW)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_ok (run & ctr_en[g]),
            .code     (ctr_code[g*8 +: 8]),
            .evt_in   (evt_in),
            .load     (ctr_load[g]),
            .load_val (ctr_load_val),
            .value    (ctr_vals[g*CW +: CW]),
            .wrap     (wrap[g])
        );
    end

    assign irq = |(irq_pend & ~irq_mask);

endmodule

// File: rtl/evt_ctr_chk.sv
module evt_ctr_chk #(
    parameter int NUM_CTR = 8,
    parameter int CW      = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [63:0]           bus_rdata,
    input logic                  bus_rvalid,
    input logic                  irq,
    input logic                  run,
    input logic [NUM_CTR-1:0]    irq_mask,
    input logic [NUM_CTR-1:0]    irq_pend,
    input logic [NUM_CTR*CW-1:0] ctr_vals
);

    a_r3_halted_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(ctr_vals));

    a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((irq_pend & $past(irq_pend)) == $past(irq_pend)));

    a_r10_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&irq_mask) |-> !irq);

    a_r10_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_pend != '0));

    a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    if (CW < 64) begin : g_narrow
        a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rvalid |-> (bus_rdata[63:48] == 16'h0));
    end

endmodule

bind evt_ctr_bank evt_ctr_chk #(
    .NUM_CTR (NUM_CTR),
    .CW      (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .run        (run),
    .irq_mask   (irq_mask),
    .irq_pend   (irq_pend),
    .ctr_vals   (ctr_vals)
);

// File: tb/evt_ctr_bank_tb.sv
module evt_ctr_bank_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [255:0] evt_in = '0;
    logic [63:0]  rd_w, rd_n;
    logic         rv_w, rv_n, irq_w, irq_n;

    int nchk = 0;
    int nbad = 0;

    logic [63:0] exp_w_q[$];
    logic [63:0] exp_n_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    evt_ctr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w),
        .bus_rvalid(rv_w), .evt_in(evt_in), .irq(irq_w)
    );

    evt_ctr_bank #(.CTR_WIDE(1'b0)) u_dut48 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_n),
        .bus_rvalid(rv_n), .evt_in(evt_in), .irq(irq_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data as each response appears
    always @(negedge clk) begin
        if (rv_w || rv_n) begin
            if (tag_q.size() == 0) begin
                chk("R12 unexpected read response", 64'(rv_w), 64'd0);
            end else begin
                string       t;
                logic [63:0] ew, en;
                t  = tag_q.pop_front();
                ew = exp_w_q.pop_front();
                en = exp_n_q.pop_front();
                chk({t, " [64-bit]"}, rd_w, ew);
                chk({t, " [48-bit]"}, rd_n, en);
            end
        end
    end

    task automatic bw(input logic [15:0] a, input logic [63:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br2(input logic [15:0] a, input logic [63:0] ew, input logic [63:0] en, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_w_q.push_back(ew);
        exp_n_q.push_back(en);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic br(input logic [15:0] a, input logic [63:0] e, input string tag);
        br2(a, e, e, tag);
    endtask

    task automatic pulse(input logic [255:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic bw_evt(input logic [15:0] a, input logic [63:0] v, input logic [255:0] m);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v; evt_in = m;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        chk({tag, " irq [64-bit]"}, 64'(irq_w), 64'(e));
        chk({tag, " irq [48-bit]"}, 64'(irq_n), 64'(e));
    endtask

    function automatic logic [255:0] ev(input int i);
        return 256'(1) << i;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R12 identity word
        chk_irq(1'b0, "R1 reset");
        br(16'h0408, 64'h0, "R1 run reset");
        br(16'h0800, 64'hFF, "R1 mask reset");
        br(16'h0808, 64'h0, "R1 pending reset");
        br(16'h1c00, 64'h0, "R1 enable reset");
        br(16'h1d00, 64'hFFFF_FFFF, "R1 sel0 reset");
        br(16'h1d04, 64'hFFFF_FFFF, "R1 sel1 reset");
        br(16'h1e00, 64'h0, "R1 ctr0 reset");
        br2(16'h1cf0, 64'h40, 64'h30, "R12 identity");

        // R5 selector layout: ctr0=0x05 ctr1=0x10 ctr2/3=off, ctr4=off ctr5=0x22
        bw(16'h1d00, 64'hFFFF_1005);
        bw(16'h1d04, 64'hFFFF_22FF);
        bw(16'h1c00, 64'hFF);
        bw(16'h0408, 64'h1_0000);
        br(16'h1d00, 64'hFFFF_1005, "R5 sel0 readback");
        br(16'h0408, 64'h1_0000, "R3 run readback");

        // R2 counting
        pulse(ev(5)); pulse(ev(5)); pulse(ev(5));
        pulse(ev(5) | ev(16));
        pulse(ev(34)); pulse(ev(34));
        pulse(ev(255));
        br(16'h1e00, 64'd4, "R2 ctr0 count");
        br(16'h1e08, 64'd1, "R2 ctr1 shared-cycle count");
        br(16'h1e28, 64'd2, "R5 ctr5 from upper selector");
        br(16'h1e20, 64'd0, "R6 ctr4 code off");
        br(16'h1e10, 64'd0, "R6 ctr2 code off");

        // R3 run bit cleared
        bw(16'h0408, 64'h0);
        pulse(ev(5));
        br(16'h1e00, 64'd4, "R3 halted ctr0");
        bw(16'h0408, 64'h1_0000);

        // R4 per-counter enable
        bw(16'h1c00, 64'hFE);
        pulse(ev(5)); pulse(ev(16));
        br(16'h1e00, 64'd4, "R4 disabled ctr0");
        br(16'h1e08, 64'd2, "R4 enabled ctr1");
        bw(16'h1c00, 64'hFF);

        // R7 preload then count, and write beats event
        bw(16'h1e00, 64'h0000_0001_0000_0000);
        br(16'h1e00, 64'h0000_0001_0000_0000, "R7 preload readback");
        pulse(ev(5));
        br(16'h1e00, 64'h0000_0001_0000_0001, "R7 count from preload");
        bw_evt(16'h1e00, 64'd100, ev(5));
        br(16'h1e00, 64'd100, "R7 write wins over event");

        // R8 narrow build upper bits
        bw(16'h1e28, 64'hABCD_0000_0000_0007);
        br2(16'h1e28, 64'hABCD_0000_0000_0007, 64'h7, "R8 upper bits dropped");

        // R9/R10 overflow on ctr1
        bw(16'h1e08, 64'hFFFF_FFFF_FFFF_FFFF);
        br2(16'h1e08, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF, "R8 all-ones preload");
        br(16'h0808, 64'h0, "R9 no pending before wrap");
        pulse(ev(16));
        br(16'h1e08, 64'h0, "R8 wrap to zero");
        br(16'h0808, 64'h2, "R9 pending after wrap");
        chk_irq(1'b0, "R10 masked");
        bw(16'h0800, 64'hFD);
        chk_irq(1'b1, "R10 unmasked");
        bw(16'h0800, 64'hFF);
        chk_irq(1'b0, "R10 remasked");
        bw(16'h0800, 64'hFD);

        // R11 write-one-to-clear
        bw(16'h080c, 64'h1);
        br(16'h0808, 64'h2, "R11 other bit untouched");
        chk_irq(1'b1, "R11 still pending");
        bw(16'h080c, 64'h2);
        br(16'h0808, 64'h0, "R11 cleared");
        chk_irq(1'b0, "R11 cleared");

        // R11 clear and wrap in the same cycle
        bw(16'h1e08, 64'hFFFF_FFFF_FFFF_FFFF);
        bw_evt(16'h080c, 64'h2, ev(16));
        br(16'h0808, 64'h2, "R11 wrap beats clear");
        chk_irq(1'b1, "R11 wrap beats clear");

        repeat (3) @(negedge clk);
        chk("R12 all responses seen", 64'(tag_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule